// File: doc/BRIEF.md
# Systolic Lookup-Table Cell Array

This block is a rectangular array of identical bit-level cells. Each cell takes one bit from each of its four orthogonal neighbours and forms a 4-bit index from them. That index selects one word of a private 16-by-4 table. Each bit of the selected word goes back out toward a different neighbour through a register. A bit therefore advances exactly one cell per clock, and data can travel in both directions along every row and every column at the same time.

Boundary ports feed the outward-facing inputs of the edge cells and collect their outward-facing outputs. North and south ports are indexed by column. East and west ports are indexed by row. A configuration port selects one cell by row and column and one table entry. Through it, software can write that entry or read it back, one cell at a time.

After reset every table holds the identity pattern, where entry k holds value k. An unconfigured array therefore acts as a set of straight wires: each boundary input reappears on the opposite boundary after as many cycles as there are cells in its path.

Top module: `lut_grid`

## Requirements
- R1: The table index of a cell is {north, east, south, west}, with north as bit 3 and west as bit 0.
- R2: For the selected word, bit 3 goes south, bit 2 goes west, bit 1 goes north and bit 0 goes east. Each output is registered, so an edge cell's boundary output reflects its inputs one clock later.
- R3: A synchronous active-high reset clears every cell output register, and so every boundary output, to 0.
- R4: Reset loads every table entry k with value k. An unconfigured array delivers north input column c on south output column c after ROWS cycles, and west input row r on east output row r after COLS cycles. The same holds in the two opposite directions.
- R5: When cfg_we is high at a rising edge, entry cfg_entry of the cell at (cfg_row, cfg_col) takes cfg_wdata. No other entry and no other cell changes.
- R6: cfg_rdata combinationally returns entry cfg_entry of the cell at (cfg_row, cfg_col). It returns 0 for a cell address outside the array.
- R7: A table entry keeps its value for as long as no write addresses it.
- R8: Opposite flows on the same row or column travel at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| n_in | input | COLS | Boundary input into the top row, per column |
| n_out | output | COLS | Boundary output from the top row, per column |
| s_in | input | COLS | Boundary input into the bottom row, per column |
| s_out | output | COLS | Boundary output from the bottom row, per column |
| e_in | input | ROWS | Boundary input into the rightmost column, per row |
| e_out | output | ROWS | Boundary output from the rightmost column, per row |
| w_in | input | ROWS | Boundary input into the leftmost column, per row |
| w_out | output | ROWS | Boundary output from the leftmost column, per row |
| cfg_row | input | ROW_W | Row of the addressed cell |
| cfg_col | input | COL_W | Column of the addressed cell |
| cfg_entry | input | 4 | Table entry address |
| cfg_wdata | input | 4 | Data to write into the entry |
| cfg_we | input | 1 | Write strobe |
| cfg_rdata | output | 4 | Readback of the addressed entry |

## Verification
On every cycle, assertions inside each table check three things. A written entry reads back on the following cycle. Entries with no write stay stable. Every entry holds its own address right after reset. Each cell also asserts that its outputs are zero after reset. Only the bench scenarios can show the index bit order and the output bit routing, the multi-cycle straight-through latency across the array, opposite flows sharing a line, and the fact that a write leaves neighbouring cells untouched.

// File: rtl/lutgrid_pkg.sv
package lutgrid_pkg;
    localparam int LUT_IN    = 4;
    localparam int LUT_DEPTH = 1 << LUT_IN;

    typedef logic [LUT_IN-1:0] lut_word_t;

    // output word bit positions (one per neighbour direction)
    localparam int OBIT_E = 0;
    localparam int OBIT_N = 1;
    localparam int OBIT_W = 2;
    localparam int OBIT_S = 3;
endpackage

// File: rtl/lut_table.sv
module lut_table
    import lutgrid_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  lut_word_t wr_addr,
    input  lut_word_t wdata,
    input  lut_word_t look_addr,
    output lut_word_t look_data,
    input  lut_word_t rd_addr,
    output lut_word_t rd_data
);
    lut_word_t mem [LUT_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LUT_DEPTH; k++) mem[k] <= lut_word_t'(k);
        end else if (we) begin
            mem[wr_addr] <= wdata;
        end
    end

    assign look_data = mem[look_addr];
    assign rd_data   = mem[rd_addr];

    // R5: a written entry reads back on the next cycle
    assert_write_readback_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && !$past(rst) && rd_addr == $past(wr_addr)) |-> rd_data == $past(wdata));

    // R4: identity content right after reset
    assert_reset_identity_R4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rd_data == rd_addr);

    // R7: without a write the addressed entry holds its value
    assert_table_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(we) && !$past(rst) && $stable(rd_addr)) |-> $stable(rd_data));
endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lutgrid_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_n,
    input  logic      in_e,
    input  logic      in_s,
    input  logic      in_w,
    output logic      out_n,
    output logic      out_e,
    output logic      out_s,
    output logic      out_w,
    input  logic      cfg_we,
    input  lut_word_t cfg_entry,
    input  lut_word_t cfg_wdata,
    output lut_word_t cfg_rdata
);
    lut_word_t idx;
    lut_word_t word;

    assign idx = {in_n, in_e, in_s, in_w};

    lut_table u_table (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .wr_addr   (cfg_entry),
        .wdata     (cfg_wdata),
        .look_addr (idx),
        .look_data (word),
        .rd_addr   (cfg_entry),
        .rd_data   (cfg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_n <= 1'b0;
            out_e <= 1'b0;
            out_s <= 1'b0;
            out_w <= 1'b0;
        end else begin
            out_n <= word[OBIT_N];
            out_e <= word[OBIT_E];
            out_s <= word[OBIT_S];
            out_w <= word[OBIT_W];
        end
    end

    // R3: outputs are cleared by reset
    assert_reset_clear_R3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> {out_n, out_e, out_s, out_w} == 4'b0000);
endmodule

// File: rtl/grid_readmux.sv
module grid_readmux
    import lutgrid_pkg::*;
#(
    parameter int CELLS = 16,
    parameter int SEL_W = 4
) (
    input  logic [CELLS*LUT_IN-1:0] flat,
    input  logic [SEL_W-1:0]        sel,
    input  logic                    valid,
    output lut_word_t               data
);
    always_comb begin
        data = '0;
        for (int i = 0; i < CELLS; i++) begin
            if (valid && sel == SEL_W'(i)) data = flat[i*LUT_IN +: LUT_IN];
        end
    end
endmodule

// File: rtl/lut_grid.sv
module lut_grid
    import lutgrid_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COLS-1:0]   n_in,
    output logic [COLS-1:0]   n_out,
    input  logic [COLS-1:0]   s_in,
    output logic [COLS-1:0]   s_out,
    input  logic [ROWS-1:0]   e_in,
    output logic [ROWS-1:0]   e_out,
    input  logic [ROWS-1:0]   w_in,
    output logic [ROWS-1:0]   w_out,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic [COL_W-1:0]  cfg_col,
    input  logic [3:0]        cfg_entry,
    input  logic [3:0]        cfg_wdata,
    input  logic              cfg_we,
    output logic [3:0]        cfg_rdata
);
    localparam int CELLS = ROWS * COLS;
    localparam int IDX_W = (CELLS > 1) ? $clog2(CELLS) : 1;

    logic i_n [ROWS][COLS];
    logic i_e [ROWS][COLS];
    logic i_s [ROWS][COLS];
    logic i_w [ROWS][COLS];
    logic o_n [ROWS][COLS];
    logic o_e [ROWS][COLS];
    logic o_s [ROWS][COLS];
    logic o_w [ROWS][COLS];

    logic [CELLS*LUT_IN-1:0] rd_flat;
    logic [IDX_W-1:0]        cell_sel;
    logic                    sel_valid;

    assign sel_valid = (int'(cfg_row) < ROWS) && (int'(cfg_col) < COLS);
    assign cell_sel  = IDX_W'(int'(cfg_row) * COLS + int'(cfg_col));

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            if (r == 0) begin : g_top
                assign i_n[r][c] = n_in[c];
                assign n_out[c]  = o_n[r][c];
            end else begin : g_vin
                assign i_n[r][c] = o_s[r-1][c];
            end
            if (r == ROWS-1) begin : g_bot
                assign i_s[r][c] = s_in[c];
                assign s_out[c]  = o_s[r][c];
            end else begin : g_vup
                assign i_s[r][c] = o_n[r+1][c];
            end
            if (c == 0) begin : g_left
                assign i_w[r][c] = w_in[r];
                assign w_out[r]  = o_w[r][c];
            end else begin : g_hin
                assign i_w[r][c] = o_e[r][c-1];
            end
            if (c == COLS-1) begin : g_right
                assign i_e[r][c] = e_in[r];
                assign e_out[r]  = o_e[r][c];
            end else begin : g_hback
                assign i_e[r][c] = o_w[r][c+1];
            end

            logic hit;
            assign hit = cfg_we && cfg_row == ROW_W'(r) && cfg_col == COL_W'(c);

            lut_cell u_cell (
                .clk       (clk),
                .rst       (rst),
                .in_n      (i_n[r][c]),
                .in_e      (i_e[r][c]),
                .in_s      (i_s[r][c]),
                .in_w      (i_w[r][c]),
                .out_n     (o_n[r][c]),
                .out_e     (o_e[r][c]),
                .out_s     (o_s[r][c]),
                .out_w     (o_w[r][c]),
                .cfg_we    (hit),
                .cfg_entry (cfg_entry),
                .cfg_wdata (cfg_wdata),
                .cfg_rdata (rd_flat[(r*COLS+c)*LUT_IN +: LUT_IN])
            );
        end
    end

    grid_readmux #(.CELLS(CELLS), .SEL_W(IDX_W)) u_rdmux (
        .flat  (rd_flat),
        .sel   (cell_sel),
        .valid (sel_valid),
        .data  (cfg_rdata)
    );
endmodule

// File: tb/lut_grid_test.sv
`timescale 1ns/1ps
module lut_grid_test;
    localparam int ROWS = 4;
    localparam int COLS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [COLS-1:0] n_in, n_out, s_in, s_out;
    logic [ROWS-1:0] e_in, e_out, w_in, w_out;
    logic [1:0] cfg_row, cfg_col;
    logic [3:0] cfg_entry, cfg_wdata, cfg_rdata;
    logic cfg_we;

    lut_grid #(.ROWS(ROWS), .COLS(COLS)) uut (
        .clk(clk), .rst(rst),
        .n_in(n_in), .n_out(n_out), .s_in(s_in), .s_out(s_out),
        .e_in(e_in), .e_out(e_out), .w_in(w_in), .w_out(w_out),
        .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_entry(cfg_entry),
        .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         due;
        int         port;
        logic [3:0] val;
        string      req;
    } exp_t;
    exp_t sb[$];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] port_val(int p);
        case (p)
            0: return s_out;
            1: return n_out;
            2: return e_out;
            3: return w_out;
            4: return {3'b000, w_out[0]};
            default: return {3'b000, n_out[0]};
        endcase
    endfunction

    // corner-cell test function: west out = n & ~w, north out = n | w
    function automatic logic [3:0] corner_fn(int k);
        logic n, w;
        n = k[3];
        w = k[0];
        return {1'b0, n & ~w, n | w, 1'b0};
    endfunction

    // monitor: compare scoreboard items when they fall due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t it;
            it = sb.pop_front();
            check(it.req, port_val(it.port), it.val);
        end
    end

    task automatic push(int due, int port, logic [3:0] val, string req);
        exp_t it;
        it.due = due; it.port = port; it.val = val; it.req = req;
        sb.push_back(it);
    endtask

    task automatic readback(int r, int c, int k, logic [3:0] exp, string req);
        cfg_row = 2'(r); cfg_col = 2'(c); cfg_entry = 4'(k);
        #0.5;
        check(req, cfg_rdata, exp);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        n_in = '0; s_in = '0; e_in = '0; w_in = '0;
        cfg_row = '0; cfg_col = '0; cfg_entry = '0; cfg_wdata = '0; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R3: outputs zero after reset
        check("R3 n_out", n_out, 4'h0);
        check("R3 s_out", s_out, 4'h0);
        check("R3 e_out", e_out, 4'h0);
        check("R3 w_out", w_out, 4'h0);

        // R4 / R6: identity tables visible through readback
        readback(0, 0, 0, 4'h0, "R4 R6 identity (0,0)");
        readback(2, 3, 7, 4'h7, "R4 R6 identity (2,3)");
        readback(3, 1, 15, 4'hF, "R4 R6 identity (3,1)");

        // R4 / R8: straight-through streams in all four directions at once
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            n_in = lf[3:0]; s_in = lf[7:4]; w_in = lf[11:8]; e_in = lf[15:12];
            push(cyc + ROWS, 0, lf[3:0],   "R4 north to south");
            push(cyc + ROWS, 1, lf[7:4],   "R8 south to north");
            push(cyc + COLS, 2, lf[11:8],  "R4 west to east");
            push(cyc + COLS, 3, lf[15:12], "R8 east to west");
        end
        @(negedge clk);
        n_in = '0; s_in = '0; e_in = '0; w_in = '0;
        repeat (10) @(negedge clk);

        // R5: program the corner cell
        for (int k = 0; k < 16; k++) begin
            cfg_row = 2'd0; cfg_col = 2'd0; cfg_entry = 4'(k);
            cfg_wdata = corner_fn(k); cfg_we = 1'b1;
            @(negedge clk);
        end
        cfg_we = 1'b0;
        for (int k = 0; k < 16; k += 5) readback(0, 0, k, corner_fn(k), "R5 R6 written entry");
        readback(0, 1, 9, 4'h9, "R5 neighbour (0,1) untouched");
        readback(1, 0, 6, 4'h6, "R5 neighbour (1,0) untouched");
        readback(3, 3, 0, 4'h0, "R5 far cell untouched");

        // R1 / R2: corner cell function, one cycle to its boundary outputs
        for (int i = 0; i < 8; i++) begin
            logic n, w;
            @(negedge clk);
            n = i[0] ^ i[2];
            w = i[1];
            n_in[0] = n; w_in[0] = w;
            push(cyc + 1, 4, {3'b000, n & ~w}, "R1 R2 west output");
            push(cyc + 1, 5, {3'b000, n | w},  "R1 R2 north output");
        end
        @(negedge clk);
        n_in = '0; w_in = '0;
        repeat (24) @(negedge clk);

        // R7: retention without writes
        for (int k = 0; k < 16; k += 3) readback(0, 0, k, corner_fn(k), "R7 entry retained");

        // R3 / R4: reset in mid-run
        n_in = 4'hF; w_in = 4'hF;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R3 n_out mid reset", n_out, 4'h0);
        check("R3 s_out mid reset", s_out, 4'h0);
        check("R3 w_out mid reset", w_out, 4'h0);
        readback(0, 0, 9, 4'h9, "R4 identity reloaded");
        n_in = '0; w_in = '0;
        rst = 1'b0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule